// File: doc/BRIEF.md
# Power Mode Controller

This block is a finite-state machine that decides which power mode a battery monitor sits in. It can be in one of five modes: full operation, a light sleep, a deep sleep, a terminal off state, and an alternative off state that waits for a charger or load attach. A configuration word sets how the machine behaves. That word selects whether a die overtemperature event may switch the part off, and whether it may do so during deep sleep. It also selects whether a load-detect edge ends deep sleep, whether the off state is replaced by a wait-for-attach state, and which supplies stay up in deep sleep.

The host drives single-cycle command pulses: enter and leave deep sleep, allow or forbid light sleep, and request power-off. The thermal sensor, the low-current indication and the load-detect pin arrive as plain inputs. The load-detect pin is asynchronous and passes through a synchronizer and an edge detector before the machine uses it. The regulators and the low-frequency oscillator are represented only by enable outputs.

Top module: `power_mode_ctrl`

## Requirements
- R1: After reset the configuration word equals 0x2982. A pulse on `cfg_load` replaces the word with `cfg_data` at the next clock edge.
- R2: After reset `sleep_en` takes the value of configuration bit 8 at reset (1 by default). After that, only `cmd_sleep_on` sets it and only `cmd_sleep_off` clears it; if both are asserted together, clear wins. A configuration write does not change `sleep_en`.
- R3: `mode` encodes the modes as follows: NORMAL=0, SLEEP=1, DEEP=2, OFF=3, WAIT=4. The machine moves from NORMAL to SLEEP when `sleep_en` and `low_current` are both 1. It moves from SLEEP back to NORMAL when either of them is 0.
- R4: `cmd_deep_enter` moves the machine from NORMAL or SLEEP to DEEP. `cmd_deep_exit` moves it from DEEP to NORMAL.
- R5: With configuration bit 11 set, a rising edge on `ld_pin` moves DEEP to NORMAL on the third clock edge after the pin rises. With bit 11 clear, a rising edge on `ld_pin` leaves the machine in DEEP.
- R6: With configuration bit 7 set, `die_ot` in NORMAL or SLEEP causes the power-off transition. With bit 7 clear, `die_ot` never causes it.
- R7: In DEEP, `die_ot` causes the power-off transition only when configuration bits 13 and 7 are both set. Otherwise the machine stays in DEEP.
- R8: With configuration bit 12 set, every power-off transition goes to WAIT instead of OFF. WAIT ignores commands and `die_ot`, and leaves to NORMAL only on a rising edge of `ld_pin`.
- R9: `reg_en` is all ones in NORMAL and SLEEP. On entry to DEEP it clears to zero when configuration bit 10 is 0, and keeps its value when bit 10 is 1. Returning to NORMAL sets it to all ones again.
- R10: `lfo_en` is 1 in NORMAL and SLEEP. In DEEP it equals configuration bit 9.
- R11: OFF holds until reset, whatever the inputs do. In OFF and in WAIT, `reg_en` and `lfo_en` are 0.
- R12: In the same cycle, a power-off request (`cmd_shutdown` or a qualifying `die_ot`) takes priority over `cmd_deep_enter` and the sleep entry condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Write strobe for the configuration word |
| cfg_data | input | CFG_W | New configuration word |
| cmd_deep_enter | input | 1 | Host pulse: enter deep sleep |
| cmd_deep_exit | input | 1 | Host pulse: leave deep sleep |
| cmd_sleep_on | input | 1 | Host pulse: allow light sleep |
| cmd_sleep_off | input | 1 | Host pulse: forbid light sleep |
| cmd_shutdown | input | 1 | Host pulse: request power-off |
| die_ot | input | 1 | Die overtemperature flag |
| low_current | input | 1 | Low pack current indication |
| ld_pin | input | 1 | Asynchronous load-detect pin |
| mode | output | 3 | Current mode code |
| reg_en | output | NUM_REG | Regulator enables |
| lfo_en | output | 1 | Low-frequency oscillator enable |
| sleep_en | output | 1 | Light-sleep permission status |

## Verification
The bench builds the block with its default parameters: a 16-bit word that resets to 0x2982, a two-stage synchronizer and two regulators. Because of this, the reset-time sleep permission and the three-edge load-detect latency are fixed values the bench can check exactly. The bench then loads other configuration words at run time: 0x2F82, 0x2182, 0x2902, 0x0982 and 0x3982. These reach each feature bit in its non-default state: supply retention, disabled load wake, masked overtemperature, overtemperature ignored in deep sleep, and the wait-for-attach substitute.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      LPM_NORMAL = 3'd0,
      LPM_SLEEP  = 3'd1,
      LPM_DEEP   = 3'd2,
      LPM_OFF    = 3'd3,
      LPM_WAIT   = 3'd4
   } lpm_mode_e;

   // positions of the behaviour-defining fields of the configuration word
   localparam int unsigned BIT_OT_DEEP    = 13;
   localparam int unsigned BIT_OFF_ALT    = 12;
   localparam int unsigned BIT_LD_WAKE    = 11;
   localparam int unsigned BIT_KEEP_REG   = 10;
   localparam int unsigned BIT_KEEP_LFO   = 9;
   localparam int unsigned BIT_SLEEP_DFLT = 8;
   localparam int unsigned BIT_OT_EN      = 7;
   localparam int unsigned CFG_MIN_W      = BIT_OT_DEEP + 1;

   typedef struct packed {
      logic ot_deep;
      logic off_alt;
      logic ld_wake;
      logic keep_reg;
      logic keep_lfo;
      logic ot_en;
   } lpm_ctl_t;

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg import lpm_pkg::*; #(
   parameter int unsigned     CFG_W   = 16,
   parameter logic [CFG_W-1:0] CFG_RST = 16'h2982
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [CFG_W-1:0] cfg_data,
   input  logic             cmd_sleep_on,
   input  logic             cmd_sleep_off,
   output lpm_ctl_t         ctl,
   output logic             sleep_en
);

   generate
      if (CFG_W < CFG_MIN_W) begin : g_width_bad
         $error("lpm_cfg_reg: CFG_W too small for the field map");
      end
   endgenerate

   localparam logic SLEEP_INIT = CFG_RST[BIT_SLEEP_DFLT];

   logic [CFG_W-1:0] cfg_q;
   logic             unused_cfg_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST;
      end else if (cfg_load) begin
         cfg_q <= cfg_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_en <= SLEEP_INIT;
      end else if (cmd_sleep_off) begin
         sleep_en <= 1'b0;
      end else if (cmd_sleep_on) begin
         sleep_en <= 1'b1;
      end
   end

   assign ctl.ot_deep  = cfg_q[BIT_OT_DEEP];
   assign ctl.off_alt  = cfg_q[BIT_OFF_ALT];
   assign ctl.ld_wake  = cfg_q[BIT_LD_WAKE];
   assign ctl.keep_reg = cfg_q[BIT_KEEP_REG];
   assign ctl.keep_lfo = cfg_q[BIT_KEEP_LFO];
   assign ctl.ot_en    = cfg_q[BIT_OT_EN];

   assign unused_cfg_bits = ^cfg_q;

   // R1
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> cfg_q == $past(cfg_data));

   // R2
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_sleep_on && !cmd_sleep_off) |=> $stable(sleep_en));

   // R2
   sleep_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_sleep_off |=> !sleep_en);

endmodule

// File: rtl/lpm_edge_sync.sv
module lpm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_stages_bad
         $error("lpm_edge_sync: at least two synchronizer stages required");
      end
   endgenerate

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
   logic [STAGES:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi <= STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // R5
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm import lpm_pkg::*; #(
   parameter int unsigned NUM_REG = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  lpm_ctl_t           ctl,
   input  logic               sleep_en,
   input  logic               low_current,
   input  logic               cmd_deep_on,
   input  logic               cmd_deep_off,
   input  logic               cmd_off,
   input  logic               die_ot,
   input  logic               ld_rise,
   output lpm_mode_e          mode,
   output logic [NUM_REG-1:0] reg_en,
   output logic               lfo_en
);

   generate
      if (NUM_REG < 1) begin : g_reg_bad
         $error("lpm_fsm: NUM_REG must be at least one");
      end
   endgenerate

   lpm_mode_e          state_q, state_d;
   logic [NUM_REG-1:0] reg_q, reg_d;
   logic               awake, active, ot_hit, off_req;
   lpm_mode_e          off_target;

   assign awake      = (state_q == LPM_NORMAL) || (state_q == LPM_SLEEP);
   assign active     = awake || (state_q == LPM_DEEP);
   assign ot_hit     = die_ot && ctl.ot_en && ((state_q != LPM_DEEP) || ctl.ot_deep);
   assign off_req    = active && (cmd_off || ot_hit);
   assign off_target = ctl.off_alt ? LPM_WAIT : LPM_OFF;

   always_comb begin
      state_d = state_q;
      if (off_req) begin
         state_d = off_target;
      end else begin
         case (state_q)
            LPM_NORMAL: begin
               if (cmd_deep_on)                  state_d = LPM_DEEP;
               else if (sleep_en && low_current) state_d = LPM_SLEEP;
            end
            LPM_SLEEP: begin
               if (cmd_deep_on)                    state_d = LPM_DEEP;
               else if (!sleep_en || !low_current) state_d = LPM_NORMAL;
            end
            LPM_DEEP: begin
               if (cmd_deep_off || (ctl.ld_wake && ld_rise)) state_d = LPM_NORMAL;
            end
            LPM_WAIT: begin
               if (ld_rise) state_d = LPM_NORMAL;
            end
            LPM_OFF:  state_d = LPM_OFF;
            default:  state_d = LPM_OFF;
         endcase
      end
   end

   always_comb begin
      case (state_d)
         LPM_NORMAL, LPM_SLEEP: reg_d = '1;
         LPM_DEEP: begin
            if (state_q == LPM_DEEP || ctl.keep_reg) reg_d = reg_q;
            else                                     reg_d = '0;
         end
         default: reg_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LPM_NORMAL;
         reg_q   <= '1;
      end else begin
         state_q <= state_d;
         reg_q   <= reg_d;
      end
   end

   always_comb begin
      case (state_q)
         LPM_NORMAL, LPM_SLEEP: lfo_en = 1'b1;
         LPM_DEEP:              lfo_en = ctl.keep_lfo;
         default:               lfo_en = 1'b0;
      endcase
   end

   assign mode   = state_q;
   assign reg_en = reg_q;

   // R11
   off_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == LPM_OFF |=> state_q == LPM_OFF);

   // R11
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_OFF || state_q == LPM_WAIT) |-> (reg_en == '0 && !lfo_en));

   // R6
   ot_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !ctl.ot_en && !cmd_off) |=> (state_q != LPM_OFF && state_q != LPM_WAIT));

   // R7
   deep_ot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_DEEP && !ctl.ot_deep && !cmd_off) |=>
      (state_q == LPM_DEEP || state_q == LPM_NORMAL));

   // R5
   ld_wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_DEEP && !ctl.ld_wake && !cmd_deep_off && !off_req) |=>
      state_q == LPM_DEEP);

   // R8
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_WAIT && !ld_rise) |=> state_q == LPM_WAIT);

   // R9
   deep_reg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_DEEP && state_d == LPM_DEEP) |=> $stable(reg_en));

   // R12
   off_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && cmd_off) |=> (state_q == LPM_OFF || state_q == LPM_WAIT));

endmodule

// File: rtl/power_mode_ctrl.sv
module power_mode_ctrl import lpm_pkg::*; #(
   parameter int unsigned      CFG_W       = 16,
   parameter logic [CFG_W-1:0] CFG_RST     = 16'h2982,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter int unsigned      NUM_REG     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [CFG_W-1:0]   cfg_data,
   input  logic               cmd_deep_enter,
   input  logic               cmd_deep_exit,
   input  logic               cmd_sleep_on,
   input  logic               cmd_sleep_off,
   input  logic               cmd_shutdown,
   input  logic               die_ot,
   input  logic               low_current,
   input  logic               ld_pin,
   output logic [2:0]         mode,
   output logic [NUM_REG-1:0] reg_en,
   output logic               lfo_en,
   output logic               sleep_en
);

   lpm_ctl_t  ctl;
   logic      ld_rise;
   lpm_mode_e fsm_mode;

   lpm_cfg_reg #(
      .CFG_W   (CFG_W),
      .CFG_RST (CFG_RST)
   ) u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_load      (cfg_load),
      .cfg_data      (cfg_data),
      .cmd_sleep_on  (cmd_sleep_on),
      .cmd_sleep_off (cmd_sleep_off),
      .ctl           (ctl),
      .sleep_en      (sleep_en)
   );

   lpm_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_ld (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ld_pin),
      .rise  (ld_rise)
   );

   lpm_fsm #(
      .NUM_REG (NUM_REG)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl          (ctl),
      .sleep_en     (sleep_en),
      .low_current  (low_current),
      .cmd_deep_on  (cmd_deep_enter),
      .cmd_deep_off (cmd_deep_exit),
      .cmd_off      (cmd_shutdown),
      .die_ot       (die_ot),
      .ld_rise      (ld_rise),
      .mode         (fsm_mode),
      .reg_en       (reg_en),
      .lfo_en       (lfo_en)
   );

   assign mode = fsm_mode;

   // R3
   sleep_needs_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 && !sleep_en) |=> mode != 3'd1);

endmodule

// File: tb/power_mode_ctrl_tb.sv
module power_mode_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [15:0] cfg_data = '0;
   logic        cmd_deep_enter = 1'b0, cmd_deep_exit = 1'b0;
   logic        cmd_sleep_on = 1'b0, cmd_sleep_off = 1'b0, cmd_shutdown = 1'b0;
   logic        die_ot = 1'b0, low_current = 1'b0, ld_pin = 1'b0;
   logic [2:0]  mode;
   logic [1:0]  reg_en;
   logic        lfo_en, sleep_en;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   power_mode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data),
      .cmd_deep_enter(cmd_deep_enter), .cmd_deep_exit(cmd_deep_exit),
      .cmd_sleep_on(cmd_sleep_on), .cmd_sleep_off(cmd_sleep_off),
      .cmd_shutdown(cmd_shutdown), .die_ot(die_ot), .low_current(low_current),
      .ld_pin(ld_pin), .mode(mode), .reg_en(reg_en), .lfo_en(lfo_en),
      .sleep_en(sleep_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cfg_load = 1'b0; cmd_deep_enter = 1'b0; cmd_deep_exit = 1'b0;
      cmd_sleep_on = 1'b0; cmd_sleep_off = 1'b0; cmd_shutdown = 1'b0;
      die_ot = 1'b0; low_current = 1'b0; ld_pin = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic load_cfg(input logic [15:0] v);
      cfg_data = v; cfg_load = 1'b1;
      step(1);
      cfg_load = 1'b0;
   endtask

   task automatic ld_edge_wait();
      ld_pin = 1'b1;
      step(3);
   endtask

   task automatic ld_release();
      ld_pin = 1'b0;
      step(3);
   endtask

   task automatic go_deep();
      cmd_deep_enter = 1'b1; step(1); cmd_deep_enter = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R3 reset mode", mode, 0);
      chk("R9 reset reg_en", reg_en, 2'b11);
      chk("R10 reset lfo_en", lfo_en, 1);
      chk("R2 reset sleep_en", sleep_en, 1);
   endtask

   task automatic t_sleep();
      do_reset();
      low_current = 1'b1; step(1);
      chk("R3 enter sleep", mode, 1);
      chk("R10 lfo in sleep", lfo_en, 1);
      cmd_sleep_off = 1'b1; step(1); cmd_sleep_off = 1'b0;
      chk("R2 sleep_off clears", sleep_en, 0);
      step(1);
      chk("R3 leave sleep on perm clear", mode, 0);
      cmd_sleep_on = 1'b1; step(1); cmd_sleep_on = 1'b0;
      chk("R2 sleep_on sets", sleep_en, 1);
      load_cfg(16'h2882);
      chk("R2 cfg write leaves sleep_en", sleep_en, 1);
      chk("R3 re-enter sleep", mode, 1);
      low_current = 1'b0; step(1);
      chk("R3 leave sleep on current", mode, 0);
      cmd_sleep_on = 1'b1; cmd_sleep_off = 1'b1; step(1);
      cmd_sleep_on = 1'b0; cmd_sleep_off = 1'b0;
      chk("R2 off wins", sleep_en, 0);
   endtask

   task automatic t_deep();
      do_reset();
      go_deep();
      chk("R4 deep entry", mode, 2);
      chk("R9 regs off in deep", reg_en, 2'b00);
      chk("R10 lfo off in deep", lfo_en, 0);
      cmd_deep_exit = 1'b1; step(1); cmd_deep_exit = 1'b0;
      chk("R4 deep exit", mode, 0);
      chk("R9 regs restored", reg_en, 2'b11);
      chk("R10 lfo restored", lfo_en, 1);
      low_current = 1'b1; step(1);
      go_deep();
      chk("R4 deep from sleep", mode, 2);
      low_current = 1'b0;
      do_reset();
      load_cfg(16'h2F82);
      go_deep();
      chk("R9 regs kept", reg_en, 2'b11);
      chk("R10 lfo kept", lfo_en, 1);
   endtask

   task automatic t_ld();
      do_reset();
      go_deep();
      ld_edge_wait();
      chk("R5 ld wake", mode, 0);
      ld_release();
      load_cfg(16'h2182);
      go_deep();
      ld_edge_wait();
      step(2);
      chk("R5 ld ignored", mode, 2);
      ld_release();
      cmd_deep_exit = 1'b1; step(1); cmd_deep_exit = 1'b0;
      chk("R4 exit without ld wake", mode, 0);
   endtask

   task automatic t_ot();
      do_reset();
      die_ot = 1'b1; step(1); die_ot = 1'b0;
      chk("R6 ot shutdown", mode, 3);
      chk("R11 regs off", reg_en, 2'b00);
      chk("R11 lfo off", lfo_en, 0);
      cmd_deep_exit = 1'b1; cmd_sleep_on = 1'b1; ld_pin = 1'b1; step(4);
      cmd_deep_exit = 1'b0; cmd_sleep_on = 1'b0; ld_pin = 1'b0;
      chk("R11 off terminal", mode, 3);
      do_reset();
      cmd_shutdown = 1'b1; cmd_deep_enter = 1'b1; step(1);
      cmd_shutdown = 1'b0; cmd_deep_enter = 1'b0;
      chk("R12 shutdown beats deep", mode, 3);
      do_reset();
      load_cfg(16'h2902);
      die_ot = 1'b1; step(2);
      chk("R6 ot masked", mode, 0);
      go_deep();
      step(1);
      chk("R6 ot masked in deep", mode, 2);
      die_ot = 1'b0;
   endtask

   task automatic t_deep_ot();
      do_reset();
      load_cfg(16'h0982);
      go_deep();
      die_ot = 1'b1; step(2); die_ot = 1'b0;
      chk("R7 deep ot ignored", mode, 2);
      load_cfg(16'h2982);
      die_ot = 1'b1; step(1); die_ot = 1'b0;
      chk("R7 deep ot shutdown", mode, 3);
   endtask

   task automatic t_wait();
      do_reset();
      load_cfg(16'h3982);
      cmd_shutdown = 1'b1; step(1); cmd_shutdown = 1'b0;
      chk("R8 wait instead of off", mode, 4);
      chk("R11 regs off in wait", reg_en, 2'b00);
      chk("R11 lfo off in wait", lfo_en, 0);
      cmd_deep_exit = 1'b1; die_ot = 1'b1; step(2);
      cmd_deep_exit = 1'b0; die_ot = 1'b0;
      chk("R8 wait ignores commands", mode, 4);
      ld_edge_wait();
      chk("R8 wait leaves on ld", mode, 0);
      chk("R9 regs back after wait", reg_en, 2'b11);
      ld_release();
      die_ot = 1'b1; step(1); die_ot = 1'b0;
      chk("R8 ot goes to wait", mode, 4);
   endtask

   initial begin
      t_reset();
      t_sleep();
      t_deep();
      t_ld();
      t_ot();
      t_deep_ot();
      t_wait();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule